// File: doc/BRIEF.md
# SPI Master Transaction Engine

This block is the serial engine of an SPI master. One command starts a whole transaction. The command names one of four chip-select lines and a byte count. The engine asserts the selected line. It waits a programmed setup time. It then shifts characters out on MOSI and shifts characters in from MISO. Between characters it inserts a programmed idle gap. After the last bit it waits a programmed hold time and releases the line. Each chip-select line has its own configuration word. That word sets clock polarity and phase, bit order, character length (4 to 16 bits), chip-select polarity, the three delays, and a two-stage clock prescaler.

The character source is a holding interface. The engine reads the word on `tx_word` when it starts a character, and acknowledges the read with a one-cycle `tx_take` pulse. Each received character is presented on `rx_word` with a one-cycle `rx_stb`. A global control word carries an enable bit and a loopback bit. Clearing the enable bit stops any running transaction. Configuration words can be changed only while the engine is disabled. FIFO storage, interrupt logic and register decoding live outside this block.

Top module: `spi_xact_engine`

## Requirements
- R1: `ctl_word` bit 31 enables the engine. While it is clear, a command has no effect. Clearing it during a transaction ends the transaction within one clock: `busy` drops, every chip-select line returns to its inactive level, and SCK returns to the idle level of the aborted transaction.
- R2: Command bits 31:30 pick the chip select. Command bits 15:0 hold the byte count minus one. A transaction shifts exactly 8×(count) bits.
- R3: A configuration write (`cfg_we`, index `cfg_idx`) updates that line's word only while the enable bit is clear. A write made while the engine is enabled is dropped, and both the chip-select idle level and the next transaction keep the old settings.
- R4: Configuration bit 31 set makes SCK idle high. Configuration bit 30 clear means data is sampled on the first edge of each bit and changed on the second edge. Bit 30 set means data is changed on the first edge and sampled on the second.
- R5: Configuration bit 29 set shifts a character MSB first, starting at bit (length-1). Bit 29 clear shifts it LSB first, starting at bit 0.
- R6: Configuration bits 19:16 hold the character length minus one (3 to 15). If fewer bits remain in the transaction than one character holds, the last character shifts only the remaining bits. These are the first bits in shift order.
- R7: Each SCK half period lasts 2×(PM+1) system clocks, where PM is configuration bits 27:24. When configuration bit 28 is set, the half period is 16 times longer.
- R8: Configuration bit 20 set makes that chip-select line active low; clear makes it active high. Every line sits at its own inactive level whenever it is not selected, including while the engine is idle.
- R9: Configuration bits 15:12 (setup), 11:8 (hold) and 7:3 (gap) add that many SCK periods. Setup is added between chip-select assertion and the first SCK edge. Hold is added between the last SCK edge and deassertion. Gap is added between consecutive characters.
- R10: Loopback (`ctl_word` bit 30) takes received data from MOSI instead of the MISO pin.
- R11: `busy` rises on the clock that accepts a command and falls when the chip select deasserts. Exactly one chip-select line is active while it is high. A command issued while busy is ignored.
- R12: Each character pulses `tx_take` once and `rx_stb` once. In `rx_word`, each received bit sits at the same position as the transmitted bit it pairs with. Positions not shifted in a short last character read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_word | input | 32 | Global control: bit 31 enable, bit 30 loopback |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 2 | Chip select whose configuration is written |
| cfg_wdata | input | 32 | Configuration word |
| cmd_we | input | 1 | Command strobe |
| cmd_word | input | 32 | Command: bits 31:30 select, bits 15:0 byte count minus one |
| tx_word | input | 16 | Next character to transmit |
| tx_take | output | 1 | Pulse: `tx_word` has been consumed |
| rx_word | output | 16 | Last received character |
| rx_stb | output | 1 | Pulse: `rx_word` is new |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_line | output | 4 | Chip-select lines, per-line polarity |
| busy | output | 1 | Transaction in progress |

## Verification
The bench drives a transaction whose last character is cut short, in both bit orders. If the engine got this wrong, it would shift a whole character, overrun the byte count, or put the surviving bits at the wrong positions in `rx_word`. It drives all four clock-mode corners and compares each captured MOSI bit with the model. A phase or polarity error would shift the serial stream by half a bit, which shows up as bit mismatches. It times setup, hold, gap and the half period against the prescaler fields, including the divide-by-16 stage. It also covers the cases that must have no effect: a configuration write while enabled, a command while busy, and a command while disabled. A design that honoured any of these would show a changed chip-select level, an extra or longer character, or a start. Finally, an abort must release the chip-select line within one clock.

// File: rtl/spi_xact_pkg.sv
package spi_xact_pkg;

  typedef enum logic [2:0] {
    XS_IDLE,
    XS_SETUP,
    XS_LOAD,
    XS_SHIFT,
    XS_GAP,
    XS_HOLD
  } xs_state_e;

  typedef struct packed {
    logic       cpol;
    logic       cpha;
    logic       msb;
    logic       div16;
    logic [3:0] pm;
    logic       cspol;
    logic [3:0] clen;
    logic [3:0] bef;
    logic [3:0] aft;
    logic [4:0] gap;
  } csm_t;

  function automatic csm_t csm_decode(input logic [31:0] w);
    csm_t r;
    r.cpol  = w[31];
    r.cpha  = w[30];
    r.msb   = w[29];
    r.div16 = w[28];
    r.pm    = w[27:24];
    r.cspol = w[20];
    r.clen  = w[19:16];
    r.bef   = w[15:12];
    r.aft   = w[11:8];
    r.gap   = w[7:3];
    return r;
  endfunction

endpackage

// File: rtl/spi_xact_cfg.sv
module spi_xact_cfg #(
  parameter int NCS = 4,
  parameter int WW  = 32,
  localparam int CSW = $clog2(NCS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic                     we,
  input  logic [CSW-1:0]           idx,
  input  logic [WW-1:0]            wdata,
  output logic [NCS-1:0][WW-1:0]   words
);

  for (genvar i = 0; i < NCS; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) begin
        words[i] <= '0;
      end else if (we && !en && (idx == CSW'(i))) begin
        words[i] <= wdata;
      end
    end
  end

  // configuration is frozen while the engine runs
  assert_cfg_locked_R3: assert property (@(posedge clk) disable iff (rst)
    en |=> $stable(words));

endmodule

// File: rtl/spi_xact_clkdiv.sv
module spi_xact_clkdiv #(
  parameter int PMW = 4,
  localparam int CW = PMW + 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           run,
  input  logic           sync,
  input  logic [PMW-1:0] pm,
  input  logic           div16,
  output logic           tick
);

  logic [CW-1:0] cnt;
  logic [CW-1:0] base;
  logic [CW-1:0] lim;

  assign base = (CW'(pm) + CW'(1)) << 1;
  assign lim  = div16 ? ((base << 4) - CW'(1)) : (base - CW'(1));
  assign tick = run && !sync && (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst || !run || sync) begin
      cnt <= '0;
    end else if (cnt == lim) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  // a half period is never shorter than two system clocks
  assert_tick_spacing_R7: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

endmodule

// File: rtl/spi_xact_shift.sv
module spi_xact_shift #(
  parameter int DW = 16,
  localparam int IW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          lead,
  input  logic          trail,
  input  logic          last,
  input  logic          msb,
  input  logic          cpha,
  input  logic [IW-1:0] top_idx,
  input  logic [DW-1:0] tx_word,
  input  logic          miso_in,
  output logic          mosi,
  output logic [DW-1:0] rx_word,
  output logic          rx_stb
);

  logic [DW-1:0] txr;
  logic [DW-1:0] rxr;
  logic [DW-1:0] rx_merged;
  logic [IW-1:0] idx;
  logic [IW-1:0] nidx;
  logic [IW-1:0] start_idx;

  assign start_idx = msb ? top_idx : '0;
  assign nidx      = msb ? (idx - IW'(1)) : (idx + IW'(1));

  always_comb begin
    rx_merged = rxr;
    if (cpha) rx_merged[idx] = miso_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txr     <= '0;
      rxr     <= '0;
      idx     <= '0;
      mosi    <= 1'b0;
      rx_word <= '0;
      rx_stb  <= 1'b0;
    end else begin
      rx_stb <= 1'b0;
      if (load) begin
        txr  <= tx_word;
        rxr  <= '0;
        idx  <= start_idx;
        mosi <= tx_word[start_idx];
      end else if (lead) begin
        if (!cpha) rxr[idx] <= miso_in;
        else       mosi     <= txr[idx];
      end else if (trail) begin
        if (cpha) rxr[idx] <= miso_in;
        if (last) begin
          rx_stb  <= 1'b1;
          rx_word <= rx_merged;
        end else begin
          idx <= nidx;
          if (!cpha) mosi <= txr[nidx];
        end
      end
    end
  end

  // one strobe per character, never back to back
  assert_rx_single_R12: assert property (@(posedge clk) disable iff (rst)
    rx_stb |=> !rx_stb);

endmodule

// File: rtl/spi_xact_engine.sv
module spi_xact_engine #(
  parameter int NCS  = 4,
  parameter int DW   = 16,
  parameter int LENW = 16,
  parameter int PMW  = 4,
  localparam int CSW  = $clog2(NCS),
  localparam int IW   = $clog2(DW),
  localparam int BITW = LENW + 4,
  localparam int NCW  = IW + 1,
  localparam int WCW  = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [31:0]     ctl_word,
  input  logic            cfg_we,
  input  logic [CSW-1:0]  cfg_idx,
  input  logic [31:0]     cfg_wdata,
  input  logic            cmd_we,
  input  logic [31:0]     cmd_word,
  input  logic [DW-1:0]   tx_word,
  output logic            tx_take,
  output logic [DW-1:0]   rx_word,
  output logic            rx_stb,
  output logic            sck,
  output logic            mosi,
  input  logic            miso,
  output logic [NCS-1:0]  cs_line,
  output logic            busy
);
  import spi_xact_pkg::*;

  logic en;
  logic lp;
  assign en = ctl_word[31];
  assign lp = ctl_word[30];

  logic [NCS-1:0][31:0] words;

  spi_xact_cfg #(.NCS(NCS), .WW(32)) u_cfg (
    .clk(clk), .rst(rst), .en(en), .we(cfg_we), .idx(cfg_idx),
    .wdata(cfg_wdata), .words(words)
  );

  xs_state_e      st;
  csm_t           m;
  csm_t           nm;
  logic [CSW-1:0] sel_q;
  logic [CSW-1:0] cmd_sel;
  logic [BITW-1:0] rem;
  logic [NCW-1:0] nchar;
  logic [NCW-1:0] clen_n;
  logic [WCW-1:0] wcnt;
  logic           ph;
  logic [NCS-1:0] cs_act;
  logic           tick;
  logic           lead;
  logic           trail;
  logic           char_end;
  logic           miso_eff;

  assign cmd_sel  = cmd_word[31 -: CSW];
  assign nm       = csm_decode(words[cmd_sel]);
  assign clen_n   = NCW'(m.clen) + NCW'(1);
  assign lead     = (st == XS_SHIFT) && tick && !ph;
  assign trail    = (st == XS_SHIFT) && tick && ph;
  assign char_end = trail && (nchar == NCW'(1));
  assign miso_eff = lp ? mosi : miso;

  spi_xact_clkdiv #(.PMW(PMW)) u_div (
    .clk(clk), .rst(rst), .run(st != XS_IDLE), .sync(st == XS_LOAD),
    .pm(m.pm), .div16(m.div16), .tick(tick)
  );

  spi_xact_shift #(.DW(DW)) u_shift (
    .clk(clk), .rst(rst), .load(st == XS_LOAD), .lead(lead), .trail(trail),
    .last(char_end), .msb(m.msb), .cpha(m.cpha), .top_idx(m.clen[IW-1:0]),
    .tx_word(tx_word), .miso_in(miso_eff), .mosi(mosi),
    .rx_word(rx_word), .rx_stb(rx_stb)
  );

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign cs_line[i] = cs_act[i] ^ words[i][20];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= XS_IDLE;
      m       <= '0;
      sel_q   <= '0;
      rem     <= '0;
      nchar   <= '0;
      wcnt    <= '0;
      ph      <= 1'b0;
      sck     <= 1'b0;
      cs_act  <= '0;
      busy    <= 1'b0;
      tx_take <= 1'b0;
    end else begin
      tx_take <= 1'b0;
      if (!en && st != XS_IDLE) begin
        st     <= XS_IDLE;
        cs_act <= '0;
        busy   <= 1'b0;
        sck    <= m.cpol;
        ph     <= 1'b0;
      end else begin
        case (st)
          XS_IDLE: begin
            if (cmd_we && en) begin
              sel_q  <= cmd_sel;
              m      <= nm;
              rem    <= (BITW'(cmd_word[LENW-1:0]) + BITW'(1)) << 3;
              cs_act <= NCS'(1) << cmd_sel;
              busy   <= 1'b1;
              sck    <= nm.cpol;
              ph     <= 1'b0;
              if (nm.bef == '0) begin
                st <= XS_LOAD;
              end else begin
                wcnt <= WCW'({nm.bef, 1'b0});
                st   <= XS_SETUP;
              end
            end
          end
          XS_SETUP, XS_GAP: begin
            if (tick) begin
              if (wcnt <= WCW'(1)) st <= XS_LOAD;
              else                 wcnt <= wcnt - WCW'(1);
            end
          end
          XS_LOAD: begin
            nchar   <= (rem < BITW'(clen_n)) ? NCW'(rem) : clen_n;
            tx_take <= 1'b1;
            ph      <= 1'b0;
            st      <= XS_SHIFT;
          end
          XS_SHIFT: begin
            if (tick) begin
              if (!ph) begin
                sck <= ~m.cpol;
                ph  <= 1'b1;
              end else begin
                sck   <= m.cpol;
                ph    <= 1'b0;
                rem   <= rem - BITW'(1);
                nchar <= nchar - NCW'(1);
                if (nchar == NCW'(1)) begin
                  if (rem == BITW'(1)) begin
                    if (m.aft == '0) begin
                      st     <= XS_IDLE;
                      cs_act <= '0;
                      busy   <= 1'b0;
                    end else begin
                      wcnt <= WCW'({m.aft, 1'b0});
                      st   <= XS_HOLD;
                    end
                  end else if (m.gap == '0) begin
                    st <= XS_LOAD;
                  end else begin
                    wcnt <= WCW'({m.gap, 1'b0});
                    st   <= XS_GAP;
                  end
                end
              end
            end
          end
          XS_HOLD: begin
            if (tick) begin
              if (wcnt <= WCW'(1)) begin
                st     <= XS_IDLE;
                cs_act <= '0;
                busy   <= 1'b0;
              end else begin
                wcnt <= wcnt - WCW'(1);
              end
            end
          end
          default: st <= XS_IDLE;
        endcase
      end
    end
  end

  logic unused_bits;
  assign unused_bits = ^{ctl_word[29:0], cmd_word[29:LENW], m.cspol, m.clen[3:IW-0 > 3 ? 3 : IW-0 > 3 ? 3 : 3]};

  assert_abort_R1: assert property (@(posedge clk) disable iff (rst)
    (!en && busy) |=> !busy);

  assert_one_cs_R11: assert property (@(posedge clk) disable iff (rst)
    busy |-> ($countones(cs_act) == 1));

  assert_no_cs_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (cs_act == '0));

  assert_cmd_ignored_R11: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_we) |=> $stable(sel_q));

  assert_sck_idle_R4: assert property (@(posedge clk) disable iff (rst)
    (st != XS_SHIFT) |-> (sck == m.cpol));

endmodule

// File: tb/sim_spi_xact_engine.sv
module sim_spi_xact_engine;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] ctl_word = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic        cmd_we = 1'b0;
  logic [31:0] cmd_word = '0;
  logic [15:0] tx_word;
  logic        tx_take;
  logic [15:0] rx_word;
  logic        rx_stb;
  logic        sck;
  logic        mosi;
  logic        miso = 1'b0;
  logic [3:0]  cs_line;
  logic        busy;

  spi_xact_engine u0 (
    .clk(clk), .rst(rst), .ctl_word(ctl_word), .cfg_we(cfg_we),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cmd_we(cmd_we),
    .cmd_word(cmd_word), .tx_word(tx_word), .tx_take(tx_take),
    .rx_word(rx_word), .rx_stb(rx_stb), .sck(sck), .mosi(mosi),
    .miso(miso), .cs_line(cs_line), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [15:0] tx_q[$];
  logic [15:0] exp_q[$];
  bit          eb_q[$];
  bit          cap_q[$];
  bit          mon_en = 1;
  bit          cur_cpol = 0;
  bit          cur_cpha = 0;
  logic [15:0] seed = 16'h1d2b;

  int cyc = 0, t_cs = 0, t_first = 0, t_last = 0, t_end = 0;
  int iv1 = 0, max_iv = 0, n_edges = 0;
  logic sck_d = 1'b0;
  logic busy_d = 1'b0;

  assign tx_word = (tx_q.size() > 0) ? tx_q[0] : 16'h0;

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: serial capture, timing, scoreboard
  always @(negedge clk) begin
    cyc++;
    if (tx_take && tx_q.size() > 0) void'(tx_q.pop_front());
    if (rx_stb && mon_en) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R12 actual=%0h expected=none", rx_word);
      end else begin
        chk("R12 rx character", rx_word, exp_q.pop_front());
      end
    end
    if (busy && !busy_d) t_cs = cyc;
    if (!busy && busy_d) t_end = cyc;
    if (busy_d && (sck !== sck_d)) begin
      if (n_edges == 0) t_first = cyc;
      else begin
        if (n_edges == 1) iv1 = cyc - t_last;
        if (cyc - t_last > max_iv) max_iv = cyc - t_last;
      end
      t_last = cyc;
      n_edges++;
      if ((sck != cur_cpol) ^ cur_cpha) cap_q.push_back(mosi);
    end
    sck_d  = sck;
    busy_d = busy;
  end

  function automatic logic [31:0] mkcfg(bit cpol, bit cpha, bit msb, bit d16,
      int pm, bit pol, int clen, int bef, int aft, int gap);
    return {cpol, cpha, msb, d16, 4'(pm), 3'b0, pol, 4'(clen), 4'(bef),
            4'(aft), 5'(gap), 3'b0};
  endfunction

  task automatic wr_cfg(input int i, input logic [31:0] w);
    cfg_idx = 2'(i); cfg_wdata = w; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_xact(input int cs, input int nbytes, input int clen,
      input bit msb, input bit cpol, input bit cpha, input bit lp,
      input int half, input int bef, input int aft, input int gap,
      input bit poke, input logic [3:0] cs_exp);
    int L, rem, n, nch, bad;
    logic [15:0] w, e;
    L = clen + 1; rem = nbytes * 8; nch = 0;
    cur_cpol = cpol; cur_cpha = cpha;
    cap_q.delete(); eb_q.delete(); n_edges = 0; max_iv = 0; iv1 = 0;
    while (rem > 0) begin
      n = (rem < L) ? rem : L;
      seed = seed * 16'd5 + 16'h3b1;
      w = (L >= 16) ? seed : (seed & ((16'h1 << L) - 16'h1));
      e = '0;
      for (int j = 0; j < n; j++) begin
        int b;
        b = msb ? (L - 1 - j) : j;
        eb_q.push_back(w[b]);
        e[b] = lp ? w[b] : miso;
      end
      tx_q.push_back(w); exp_q.push_back(e);
      rem -= n; nch++;
    end
    ctl_word = {1'b1, lp, 30'b0};
    cmd_word = {2'(cs), 14'b0, 16'(nbytes - 1)};
    cmd_we = 1'b1;
    @(negedge clk);
    cmd_we = 1'b0;
    chk("R11 busy on accept", busy, 1);
    chk("R8 active chip select", cs_line, cs_exp);
    if (poke) begin
      repeat (10) @(negedge clk);
      cmd_word = {2'd3, 14'b0, 16'd4};
      cmd_we = 1'b1;
      @(negedge clk);
      cmd_we = 1'b0;
      @(negedge clk);
      chk("R11 command ignored while busy", cs_line, cs_exp);
    end
    while (busy) @(negedge clk);
    @(negedge clk);
    chk("R2 serial bit count", cap_q.size(), nbytes * 8);
    bad = 0;
    for (int k = 0; k < eb_q.size() && k < cap_q.size(); k++)
      if (cap_q[k] != eb_q[k]) bad++;
    chk("R4/R5/R6 mosi bit stream", bad, 0);
    chk("R12 all characters received", exp_q.size(), 0);
    chk("R12 all characters taken", tx_q.size(), 0);
    chk("R7 sck half period", iv1, half);
    chk("R9 setup window", ((t_first - t_cs) >= (2*bef+1)*half) &&
        ((t_first - t_cs) <= (2*bef+1)*half + 2), 1);
    chk("R9 hold window", ((t_end - t_last) >= 2*aft*half) &&
        ((t_end - t_last) <= 2*aft*half + 2), 1);
    if (gap > 0 && nch > 1)
      chk("R9 gap between characters", max_iv >= (2*gap+1)*half, 1);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 reset busy", busy, 0);
    chk("R8 reset chip selects", cs_line, 4'b0000);
    chk("R4 reset sck", sck, 0);

    wr_cfg(0, mkcfg(0, 0, 1, 0, 0, 1, 15, 0, 0, 0));
    wr_cfg(1, mkcfg(0, 0, 1, 0, 2, 1, 7, 1, 2, 1));
    wr_cfg(2, mkcfg(1, 1, 0, 0, 0, 0, 11, 0, 0, 0));
    wr_cfg(3, mkcfg(1, 0, 1, 1, 0, 1, 3, 0, 0, 0));
    @(negedge clk);
    chk("R8 idle levels per line", cs_line, 4'b1011);

    // R1: command while disabled
    cmd_word = 32'h4000_0001; cmd_we = 1'b1;
    @(negedge clk);
    cmd_we = 1'b0;
    @(negedge clk);
    chk("R1 command ignored while disabled", busy, 0);

    // R10 loopback, mode 0, MSB first, divider, delays
    do_xact(1, 3, 7, 1, 0, 0, 1, 6, 1, 2, 1, 0, 4'b1001);
    // R6 short last character, LSB first, mode 3
    do_xact(2, 2, 11, 0, 1, 1, 1, 2, 0, 0, 0, 0, 4'b1111);
    // R10 loopback off: data from miso; R6 MSB short char; R11 poke
    miso = 1'b1;
    do_xact(0, 3, 15, 1, 0, 0, 0, 2, 0, 0, 0, 1, 4'b1010);
    miso = 1'b0;

    // R3: write while enabled is dropped
    ctl_word = 32'h8000_0000;
    wr_cfg(1, mkcfg(1, 1, 0, 0, 0, 0, 3, 0, 0, 0));
    @(negedge clk);
    chk("R3 idle level unchanged", cs_line, 4'b1011);
    do_xact(1, 1, 7, 1, 0, 0, 1, 6, 1, 2, 1, 0, 4'b1001);

    // R7 divide-by-16 stage, mode 2
    do_xact(3, 1, 3, 1, 1, 0, 1, 32, 0, 0, 0, 0, 4'b0011);

    // R1 abort
    mon_en = 0;
    cur_cpol = 0; cur_cpha = 0;
    ctl_word = 32'h8000_0000;
    cmd_word = {2'd1, 14'b0, 16'd39};
    cmd_we = 1'b1;
    @(negedge clk);
    cmd_we = 1'b0;
    repeat (100) @(negedge clk);
    ctl_word = 32'h0;
    @(negedge clk);
    chk("R1 abort drops busy", busy, 0);
    chk("R1 abort releases chip select", cs_line, 4'b1011);
    chk("R1 abort idles sck", sck, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule